// File: doc/BRIEF.md
# Gated Pulse-Width Measurement Counter

This block measures the high time of an asynchronous input pulse in whole system clock cycles. The raw pulse is first resynchronized. It then passes through a small qualification state machine that produces a clean count enable. That enable changes only at clock edges, so a runt or a sub-cycle spike on the input can never reach the accumulator. The accumulator adds one per cycle under a synchronous clock enable. No derived clock is ever built.

When the qualified enable drops, the result is frozen and a done flag is raised. The host reads the count and then pulses a clear strobe. The clear empties the accumulator, drops done and the overflow bit, and re-arms the measurement. After re-arming, the block waits until it has seen the input low before it accepts a new pulse, so a pulse already in progress is never measured from its middle. The host must leave the input low long enough (at least 16 cycles) to finish its read and clear before the next pulse.

Top module: `pulse_width_meter`

## Requirements
- R1: While a measurement runs, count_o increases by exactly one for each rising clock edge at which the resynchronized pulse is high. A clean pulse held high across N rising edges ends with count_o equal to N.
- R2: The count enable is derived only from the two-flop resynchronized pulse. The pulse is first sampled high at rising edge k. count_o first reads 1 and busy_o first rises after edge k+2.
- R3: Take a pulse whose last high sample is at edge k+N-1. count_o reaches its final value after edge k+N+1. After edge k+N+2, done_o is 1 and busy_o is 0, and busy_o and done_o are never high together.
- R4: While done_o is 1 and clear_i is 0, further input pulses are ignored: count_o is held, done_o stays 1 and busy_o stays 0.
- R5: When clear_i is sampled high at a rising edge, whatever the state, count_o reads 0 and done_o, busy_o and ovf_o read 0 after that edge.
- R6: After reset or a clear, counting starts only after the resynchronized pulse has been seen low. A pulse already high at that time produces no count and no done flag.
- R7: The count saturates at all ones (2^CNT_W-1) instead of wrapping. ovf_o is set on the first enabled cycle that finds the count already at all ones, and stays set until a clear or a reset.
- R8: Asynchronous active-low reset gives count_o = 0, done_o = 0, busy_o = 0 and ovf_o = 0.
- R9: Input activity that rises and falls between two rising clock edges is never sampled and leaves count_o at 0 and done_o at 0.
- R10: With default parameters the count is 20 bits wide, and a 1000-cycle pulse reads exactly 1000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pulse_i | input | 1 | Raw asynchronous pulse to be measured |
| clear_i | input | 1 | Host strobe that clears the result and re-arms |
| count_o | output | CNT_W | Measured high time in clock cycles |
| done_o | output | 1 | Measurement complete, result held |
| busy_o | output | 1 | Measurement in progress |
| ovf_o | output | 1 | Count saturated during this measurement |

## Verification
A qualification state stuck in waiting-for-low or in armed shows up within two cycles of a pulse: count_o and busy_o fail to move at edge k+2. A state that leaves the done state without a clear shows up at the next pulse as a changed count. An enable taken from the raw pulse instead of the synchronizer shifts the first increment two cycles early, which the latency check catches at that exact cycle. Saturation faults appear only at the all-ones boundary, so a narrow instance checks the counts just below, at and beyond that boundary.

// File: rtl/pwm_pkg.sv
package pwm_pkg;
  localparam int unsigned CNT_W_DEF  = 20;
  localparam int unsigned SYNC_N_DEF = 2;

  typedef enum logic [1:0] {
    ST_WAIT_LOW = 2'd0,
    ST_ARMED    = 2'd1,
    ST_COUNT    = 2'd2,
    ST_DONE     = 2'd3
  } meas_state_e;
endpackage

// File: rtl/pwm_sync.sv
module pwm_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= d_i;
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) chain_q <= '0;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/pwm_gate_fsm.sv
module pwm_gate_fsm
  import pwm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clear_i,
  input  logic pulse_s_i,
  output logic en_o,
  output logic busy_o,
  output logic done_o
);
  meas_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (clear_i) st_d = ST_WAIT_LOW;
    else begin
      unique case (st_q)
        ST_WAIT_LOW: if (!pulse_s_i) st_d = ST_ARMED;
        ST_ARMED:    if (pulse_s_i)  st_d = ST_COUNT;
        ST_COUNT:    if (!pulse_s_i) st_d = ST_DONE;
        ST_DONE:     st_d = ST_DONE;
        default:     st_d = ST_WAIT_LOW;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) st_q <= ST_WAIT_LOW;
    else         st_q <= st_d;

  // enable comes from registered state and the synchronized pulse only
  assign en_o   = pulse_s_i && (st_q == ST_ARMED || st_q == ST_COUNT);
  assign busy_o = (st_q == ST_COUNT);
  assign done_o = (st_q == ST_DONE);

  assert_no_en_wait_low_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_WAIT_LOW) |-> !en_o);
  assert_done_after_fall_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_COUNT && !pulse_s_i && !clear_i) |=> done_o);
  assert_busy_done_excl_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_o && done_o));
endmodule

// File: rtl/pwm_sat_counter.sv
module pwm_sat_counter #(
  parameter int unsigned CNT_W = 20
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             ovf_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;
  logic             ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (clr_i) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else if (inc_i) begin
      if (cnt_q == CNT_MAX) ovf_q <= 1'b1;
      else                  cnt_q <= cnt_q + CNT_W'(1);
    end

  assign cnt_o = cnt_q;
  assign ovf_o = ovf_q;

  assert_cnt_step_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q != CNT_MAX) |=> cnt_q == $past(cnt_q) + CNT_W'(1));
  assert_no_wrap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && inc_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX && ovf_q));
  assert_idle_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && !inc_i) |=> $stable(cnt_q));
endmodule

// File: rtl/pulse_width_meter.sv
module pulse_width_meter #(
  parameter int unsigned CNT_W  = pwm_pkg::CNT_W_DEF,
  parameter int unsigned SYNC_N = pwm_pkg::SYNC_N_DEF
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pulse_i,
  input  logic             clear_i,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o,
  output logic             busy_o,
  output logic             ovf_o
);
  logic pulse_s;
  logic cnt_en;

  pwm_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (pulse_i),
    .q_o   (pulse_s)
  );

  pwm_gate_fsm u_fsm (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .clear_i  (clear_i),
    .pulse_s_i(pulse_s),
    .en_o     (cnt_en),
    .busy_o   (busy_o),
    .done_o   (done_o)
  );

  pwm_sat_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .clr_i (clear_i),
    .inc_i (cnt_en),
    .cnt_o (count_o),
    .ovf_o (ovf_o)
  );

  assert_done_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !clear_i) |=> (done_o && !busy_o && $stable(count_o)));
  assert_clear_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (count_o == '0 && !done_o && !busy_o && !ovf_o));
endmodule

// File: tb/pulse_width_meter_bench.sv
module pulse_width_meter_bench;
  localparam int unsigned NW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pulse = 1'b0, clear = 1'b0;
  logic pulse_n = 1'b0, clear_n = 1'b0;
  logic [19:0]   count;
  logic [NW-1:0] count_n;
  logic done, busy, ovf, done_n, busy_n, ovf_n;
  int checks = 0, fails = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  pulse_width_meter u_pulse_width_meter (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse), .clear_i(clear),
    .count_o(count), .done_o(done), .busy_o(busy), .ovf_o(ovf));

  pulse_width_meter #(.CNT_W(NW)) u_pulse_width_meter_narrow (
    .clk_i(clk), .rst_ni(rst_n), .pulse_i(pulse_n), .clear_i(clear_n),
    .count_o(count_n), .done_o(done_n), .busy_o(busy_n), .ovf_o(ovf_n));

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_clear();
    clear = 1'b1; wait_cyc(1); clear = 1'b0; wait_cyc(1);
  endtask

  task automatic do_clear_n();
    clear_n = 1'b1; wait_cyc(1); clear_n = 1'b0; wait_cyc(1);
  endtask

  task automatic pulse_wide(input int n);
    pulse = 1'b1; wait_cyc(n); pulse = 1'b0; wait_cyc(6);
  endtask

  task automatic pulse_narrow(input int n);
    pulse_n = 1'b1; wait_cyc(n); pulse_n = 1'b0; wait_cyc(6);
  endtask

  task automatic t_reset();
    check("R8 count", count, 0);
    check("R8 done", done, 0);
    check("R8 busy", busy, 0);
    check("R8 ovf", ovf, 0);
  endtask

  task automatic t_latency_and_done();
    pulse = 1'b1;
    wait_cyc(1); check("R2 count after k", count, 0);
    wait_cyc(1); check("R2 busy after k+1", busy, 0);
    wait_cyc(1); check("R2 count after k+2", count, 1);
    check("R2 busy after k+2", busy, 1);
    wait_cyc(4);
    pulse = 1'b0;
    wait_cyc(1); check("R3 done after k+N", done, 0);
    check("R3 busy after k+N", busy, 1);
    wait_cyc(1); check("R3 count after k+N+1", count, 7);
    check("R3 done after k+N+1", done, 0);
    wait_cyc(1); check("R3 done after k+N+2", done, 1);
    check("R3 busy after k+N+2", busy, 0);
    check("R1 final count 7", count, 7);
  endtask

  task automatic t_ignore_while_done();
    pulse = 1'b1;
    wait_cyc(3); check("R4 busy stays low", busy, 0);
    wait_cyc(2); pulse = 1'b0; wait_cyc(5);
    check("R4 count held", count, 7);
    check("R4 done held", done, 1);
  endtask

  task automatic t_clear();
    do_clear();
    check("R5 count cleared", count, 0);
    check("R5 done cleared", done, 0);
    pulse_wide(3);
    check("R1 count 3", count, 3);
    check("R1 done", done, 1);
  endtask

  task automatic t_clear_while_high();
    pulse = 1'b1; wait_cyc(2);
    do_clear();
    wait_cyc(8);
    check("R6 no count while held", count, 0);
    check("R6 no busy while held", busy, 0);
    pulse = 1'b0; wait_cyc(6);
    check("R6 no done after release", done, 0);
    pulse_wide(5);
    check("R6 next pulse counted", count, 5);
  endtask

  task automatic t_clear_mid_count();
    do_clear();
    pulse = 1'b1; wait_cyc(6);
    check("R5 busy before restart", busy, 1);
    do_clear();
    check("R5 count restarted", count, 0);
    check("R5 busy restarted", busy, 0);
    wait_cyc(4); pulse = 1'b0; wait_cyc(6);
    check("R6 remainder ignored", count, 0);
    check("R6 remainder no done", done, 0);
  endtask

  task automatic t_glitch();
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); #1 pulse = 1'b1; #2 pulse = 1'b0;
    end
    wait_cyc(6);
    check("R9 glitch count", count, 0);
    check("R9 glitch done", done, 0);
    pulse_wide(1);
    check("R1 single cycle pulse", count, 1);
    do_clear();
  endtask

  task automatic t_long();
    pulse_wide(1000);
    check("R10 long count", count, 1000);
    check("R10 no overflow", ovf, 0);
    do_clear();
  endtask

  task automatic t_saturate();
    pulse_narrow(15);
    check("R7 count at max", count_n, 15);
    check("R7 no ovf at max", ovf_n, 0);
    do_clear_n();
    pulse_narrow(16);
    check("R7 saturated count", count_n, 15);
    check("R7 ovf one past", ovf_n, 1);
    do_clear_n();
    check("R7 ovf cleared", ovf_n, 0);
    pulse_narrow(30);
    check("R7 long saturated", count_n, 15);
    check("R7 long ovf", ovf_n, 1);
    check("R7 done narrow", done_n, 1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    t_reset();
    rst_n = 1'b1;
    wait_cyc(3);
    t_reset();
    t_latency_and_done();
    t_ignore_while_done();
    t_clear();
    t_clear_while_high();
    t_clear_mid_count();
    t_glitch();
    t_long();
    t_saturate();
    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule